// File: doc/BRIEF.md
# Real-Time Clock Register Interface and Control

This block is the processor-facing side of a small real-time clock. It decodes a 4-bit address with a 4-bit data bus. It owns the control latches that start and stop timekeeping and select the mode. It also holds the tenths-of-seconds counter, the hour-mode, AM/PM and leap-year fields, and the control word for the interrupt timer.

Address 0 is asymmetric. A write loads the control latches, and a read returns two clear-on-read status flags instead of the written bits. Address 15 is a window onto two registers: the interrupt select latch decides whether it reaches the clock setting register or the interrupt control word.

The calendar counter chain and the interrupt timer are separate blocks. They receive the exported controls and return strobes: a 10 Hz tick, a year rollover and an interrupt event.

Top module: `rtc_regif`

## Requirements
- R1: After reset, `clk_halted` is 1, and `int_halted`, `test_mode`, `hour_24`, `pm_flag`, `leap_count`, `tenths`, `int_config` and both status flags are 0.
- R2: A write to address 0 loads the control latches on that clock edge, with this bit layout: bit 0 is clock halt, bit 1 is interrupt select, bit 2 is interrupt halt, and bit 3 is test mode.
- R3: A read of address 0 returns `{2'b00, time_changed, irq_pending}` and never returns the latch contents. Both flags clear on the edge that ends the read. A set event in that same cycle wins over the clear.
- R4: With interrupt select at 0, address 15 reads and writes the clock setting register. With it at 1, address 15 reads and writes `int_config`. An access through one path leaves the other register unchanged.
- R5: In the clock setting register, bit 0 is the 24-hour flag and bit 1 is the PM flag. When bit 0 is written as 1, the stored PM flag is 0.
- R6: Bits 3:2 of the clock setting register are the leap counter, and `is_leap` is 1 when the counter is 0. Each `year_roll` pulse increments the counter modulo 4. A write in the same cycle takes precedence over the pulse.
- R7: Writing 1 to the clock halt bit forces `tenths` to 0 on the same edge, and `tenths` stays 0 while halted. Writing 0 resumes counting from 0.
- R8: While the clock runs, each `tick_10hz` cycle advances `tenths` from 0 up to 9 and then back to 0. `tenths_carry` is high for exactly the one cycle in which `tenths` has just wrapped to 0.
- R9: Writing 0 to `int_config` sets `int_halted` to 1. A nonzero write leaves `int_halted` unchanged.
- R10: An `irq_fire` pulse sets the pending flag. A write to the clock setting register sets the time-changed flag. So does a control write that takes the clock from halted to running.
- R11: Addresses 1 to 14 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears status flags at address 0) |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data, 0 when not reading |
| tick_10hz | input | 1 | One-cycle 10 Hz enable |
| year_roll | input | 1 | One-cycle year rollover strobe |
| irq_fire | input | 1 | Interrupt timer event |
| clk_halted | output | 1 | Timekeeping halted |
| tenths | output | 4 | Tenths-of-seconds count |
| tenths_carry | output | 1 | One-cycle wrap pulse to the seconds counter |
| hour_24 | output | 1 | 24-hour mode |
| pm_flag | output | 1 | PM indicator |
| leap_count | output | 2 | Leap-year counter |
| is_leap | output | 1 | Current year is a leap year |
| int_halted | output | 1 | Interrupt timer halt and reset |
| int_config | output | 4 | Interrupt delay and repeat control word |
| test_mode | output | 1 | Test mode enable |

## Verification
The hardest situation to reach is a status flag being cleared by a read in the same cycle that a new event sets it. A clear on that edge would lose the event. The bench holds `irq_fire` high during an address-0 read and then reads again to confirm the flag survived. The time-changed flag is reachable only by a halted-to-running control write or a setting write. The bench therefore sequences halt, clear, restart and read explicitly.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;

    localparam int DATA_W = 4;
    localparam int ADDR_W = 4;

    // Control latch bits, MSB first: bit3 test, bit2 int halt, bit1 sel, bit0 clk halt
    typedef struct packed {
        logic test;
        logic int_halt;
        logic int_sel;
        logic clk_halt;
    } ctrl_t;

    // Clock setting register, MSB first: [3:2] leap, [1] pm, [0] 24-hour
    typedef struct packed {
        logic [1:0] leap;
        logic       pm;
        logic       hr24;
    } setting_t;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_SETTING,
        TGT_INTCFG
    } target_e;

    localparam ctrl_t CTRL_RESET = '{test: 1'b0, int_halt: 1'b0,
                                     int_sel: 1'b0, clk_halt: 1'b1};

    function automatic target_e decode(input logic [ADDR_W-1:0] a,
                                       input logic sel,
                                       input logic [ADDR_W-1:0] ctrl_a,
                                       input logic [ADDR_W-1:0] win_a);
        target_e t;
        if (a == ctrl_a)      t = TGT_CTRL;
        else if (a == win_a)  t = sel ? TGT_INTCFG : TGT_SETTING;
        else                  t = TGT_NONE;
        return t;
    endfunction

    function automatic setting_t sanitize(input logic [DATA_W-1:0] w);
        setting_t s;
        s = setting_t'(w);
        if (s.hr24) s.pm = 1'b0;
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input logic irq,
                                                      input logic chg);
        return {{(DATA_W-2){1'b0}}, chg, irq};
    endfunction

endpackage

// File: rtl/rtc_ctrl_latch.sv
module rtc_ctrl_latch
    import rtc_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_intcfg,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] int_cfg,
    output logic              restart
);

    assign restart = wr_ctrl && ctrl.clk_halt && !wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= CTRL_RESET;
            int_cfg <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl <= ctrl_t'(wdata);
            end
            if (wr_intcfg) begin
                int_cfg <= wdata;
                if (wdata == '0) ctrl.int_halt <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_setting_reg.sv
module rtc_setting_reg
    import rtc_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              year_roll,
    output setting_t          setting
);

    always_ff @(posedge clk) begin
        if (rst) begin
            setting <= '0;
        end else if (wr) begin
            setting <= sanitize(wdata);
        end else if (year_roll) begin
            setting.leap <= setting.leap + 2'd1;
        end
    end

endmodule

// File: rtl/rtc_tenths.sv
module rtc_tenths #(
    parameter int MOD   = 10,
    parameter int CNT_W = $clog2(MOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             carry
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MOD - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            carry <= 1'b0;
        end else begin
            carry <= 1'b0;
            if (halt) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == LAST) begin
                    cnt   <= '0;
                    carry <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rtc_status.sv
module rtc_status (
    input  logic clk,
    input  logic rst,
    input  logic set_irq,
    input  logic set_chg,
    input  logic rd_clr,
    output logic irq_pend,
    output logic chg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pend <= 1'b0;
            chg      <= 1'b0;
        end else begin
            irq_pend <= (irq_pend && !rd_clr) || set_irq;
            chg      <= (chg && !rd_clr) || set_chg;
        end
    end

endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
    import rtc_regif_pkg::*;
#(
    parameter int               TENTHS_MOD = 10,
    parameter logic [3:0]       CTRL_ADDR  = 4'd0,
    parameter logic [3:0]       WIN_ADDR   = 4'd15,
    localparam int              CNT_W      = $clog2(TENTHS_MOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [3:0]       wdata,
    output logic [3:0]       rdata,
    input  logic             tick_10hz,
    input  logic             year_roll,
    input  logic             irq_fire,
    output logic             clk_halted,
    output logic [CNT_W-1:0] tenths,
    output logic             tenths_carry,
    output logic             hour_24,
    output logic             pm_flag,
    output logic [1:0]       leap_count,
    output logic             is_leap,
    output logic             int_halted,
    output logic [3:0]       int_config,
    output logic             test_mode
);

    ctrl_t             ctrl;
    setting_t          setting;
    logic [DATA_W-1:0] int_cfg;
    logic              restart;
    logic              irq_pend;
    logic              chg;
    target_e           tgt;
    logic              wr_ctrl, wr_setting, wr_intcfg, rd_clr, halt_eff;

    assign tgt        = decode(addr, ctrl.int_sel, CTRL_ADDR, WIN_ADDR);
    assign wr_ctrl    = wr_en && (tgt == TGT_CTRL);
    assign wr_setting = wr_en && (tgt == TGT_SETTING);
    assign wr_intcfg  = wr_en && (tgt == TGT_INTCFG);
    assign rd_clr     = rd_en && (tgt == TGT_CTRL);
    // A halt write takes effect on the counter at the same edge
    assign halt_eff   = wr_ctrl ? wdata[0] : ctrl.clk_halt;

    rtc_ctrl_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wr_intcfg (wr_intcfg),
        .wdata     (wdata),
        .ctrl      (ctrl),
        .int_cfg   (int_cfg),
        .restart   (restart)
    );

    rtc_setting_reg u_setting (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_setting),
        .wdata     (wdata),
        .year_roll (year_roll),
        .setting   (setting)
    );

    rtc_tenths #(.MOD(TENTHS_MOD), .CNT_W(CNT_W)) u_tenths (
        .clk   (clk),
        .rst   (rst),
        .halt  (halt_eff),
        .tick  (tick_10hz),
        .cnt   (tenths),
        .carry (tenths_carry)
    );

    rtc_status u_status (
        .clk      (clk),
        .rst      (rst),
        .set_irq  (irq_fire),
        .set_chg  (restart || wr_setting),
        .rd_clr   (rd_clr),
        .irq_pend (irq_pend),
        .chg      (chg)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (tgt)
                TGT_CTRL:    rdata = status_word(irq_pend, chg);
                TGT_SETTING: rdata = setting;
                TGT_INTCFG:  rdata = int_cfg;
                default:     rdata = '0;
            endcase
        end
    end

    assign clk_halted = ctrl.clk_halt;
    assign int_halted = ctrl.int_halt;
    assign test_mode  = ctrl.test;
    assign hour_24    = setting.hr24;
    assign pm_flag    = setting.pm;
    assign leap_count = setting.leap;
    assign is_leap    = (setting.leap == 2'd0);
    assign int_config = int_cfg;

endmodule

// File: rtl/rtc_regif_chk.sv
module rtc_regif_chk #(
    parameter int         TENTHS_MOD = 10,
    parameter logic [3:0] CTRL_ADDR  = 4'd0,
    parameter logic [3:0] WIN_ADDR   = 4'd15,
    parameter int         CNT_W      = $clog2(TENTHS_MOD)
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       addr,
    input logic             wr_en,
    input logic [3:0]       wdata,
    input logic             year_roll,
    input logic             clk_halted,
    input logic [CNT_W-1:0] tenths,
    input logic             tenths_carry,
    input logic             hour_24,
    input logic             pm_flag,
    input logic [1:0]       leap_count,
    input logic             test_mode
);

    // R7
    halt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clk_halted |-> (tenths == '0));

    // R8
    carry_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tenths_carry |-> (tenths == '0) && ($past(tenths) == CNT_W'(TENTHS_MOD - 1)));

    // R5
    pm_24h_chk: assert property (@(posedge clk) disable iff (rst)
        hour_24 |-> !pm_flag);

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CTRL_ADDR) |=>
            (clk_halted == $past(wdata[0])) && (test_mode == $past(wdata[3])));

    // R6
    leap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (year_roll && !(wr_en && addr == WIN_ADDR)) |=>
            (leap_count == $past(leap_count) + 2'd1));

endmodule

bind rtc_regif rtc_regif_chk #(
    .TENTHS_MOD (TENTHS_MOD),
    .CTRL_ADDR  (CTRL_ADDR),
    .WIN_ADDR   (WIN_ADDR),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .wr_en        (wr_en),
    .wdata        (wdata),
    .year_roll    (year_roll),
    .clk_halted   (clk_halted),
    .tenths       (tenths),
    .tenths_carry (tenths_carry),
    .hour_24      (hour_24),
    .pm_flag      (pm_flag),
    .leap_count   (leap_count),
    .test_mode    (test_mode)
);

// File: tb/rtc_regif_tb.sv
module rtc_regif_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    logic       tick_10hz = 1'b0, year_roll = 1'b0, irq_fire = 1'b0;
    logic       clk_halted, tenths_carry, hour_24, pm_flag, is_leap;
    logic       int_halted, test_mode;
    logic [3:0] tenths, int_config;
    logic [1:0] leap_count;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    rtc_regif u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tick_10hz(tick_10hz),
        .year_roll(year_roll), .irq_fire(irq_fire), .clk_halted(clk_halted),
        .tenths(tenths), .tenths_carry(tenths_carry), .hour_24(hour_24),
        .pm_flag(pm_flag), .leap_count(leap_count), .is_leap(is_leap),
        .int_halted(int_halted), .int_config(int_config), .test_mode(test_mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick();
        tick_10hz = 1'b1;
        @(negedge clk);
        tick_10hz = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [3:0] d;
        logic [3:0] set_model;
        logic [3:0] exp_set;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 clk_halted", clk_halted, 1);
        chk("R1 int_halted", int_halted, 0);
        chk("R1 test_mode", test_mode, 0);
        chk("R1 hour_24", hour_24, 0);
        chk("R1 pm_flag", pm_flag, 0);
        chk("R1 leap_count", leap_count, 0);
        chk("R1 tenths", tenths, 0);
        chk("R1 int_config", int_config, 0);
        rd(4'd0, d); chk("R1 status", d, 0);

        // Seed both window registers
        wr(4'd0, 4'b0001);
        wr(4'd15, 4'b1001);
        wr(4'd0, 4'b0011);
        wr(4'd15, 4'b0110);

        // R2 / R4 sweep over all control words
        for (int v = 0; v < 16; v++) begin
            wr(4'd0, 4'(v));
            chk("R2 clk halt bit0", clk_halted, v & 1);
            chk("R2 int halt bit2", int_halted, (v >> 2) & 1);
            chk("R2 test bit3", test_mode, (v >> 3) & 1);
            rd(4'd15, d);
            chk("R4 window steering", d, ((v >> 1) & 1) ? 6 : 9);
        end

        // R5 / R6 sweep of the setting register through select 0
        wr(4'd0, 4'b0000);
        for (int v = 0; v < 16; v++) begin
            wr(4'd15, 4'(v));
            exp_set = 4'(v);
            if (v & 1) exp_set[1] = 1'b0;
            rd(4'd15, d);
            chk("R5 setting readback", d, exp_set);
            chk("R5 hour_24", hour_24, v & 1);
            chk("R5 pm_flag", pm_flag, exp_set[1]);
            chk("R6 leap field", leap_count, v >> 2);
            chk("R6 is_leap", is_leap, (v >> 2) == 0);
        end
        set_model = 4'b1101 & ~4'b0010;
        wr(4'd0, 4'b0010);
        rd(4'd15, d);
        chk("R4 int_config untouched", d, 6);

        // R9 and R4 through select 1
        for (int v = 0; v < 16; v++) begin
            wr(4'd0, 4'b0010);
            wr(4'd15, 4'(v));
            chk("R9 int_halted on zero", int_halted, v == 0);
            rd(4'd15, d);
            chk("R4 int_config readback", d, v);
            chk("R4 int_config port", int_config, v);
        end
        wr(4'd0, 4'b0000);
        rd(4'd15, d);
        chk("R4 setting untouched", d, set_model);

        // R6 leap counting
        wr(4'd15, 4'b0000);
        for (int i = 1; i <= 8; i++) begin
            year_roll = 1'b1;
            @(negedge clk);
            year_roll = 1'b0;
            chk("R6 leap count", leap_count, i % 4);
            chk("R6 is_leap", is_leap, (i % 4) == 0);
        end
        year_roll = 1'b1;
        wr(4'd15, 4'b1000);
        year_roll = 1'b0;
        chk("R6 write beats roll", leap_count, 2);

        // R3 / R10 status flags
        rd(4'd0, d);
        rd(4'd0, d); chk("R3 cleared", d, 0);
        irq_fire = 1'b1; @(negedge clk); irq_fire = 1'b0;
        rd(4'd0, d); chk("R10 irq pending", d, 1);
        rd(4'd0, d); chk("R3 clear on read", d, 0);
        wr(4'd0, 4'b0001);
        rd(4'd0, d); chk("R10 halt alone sets nothing", d, 0);
        wr(4'd0, 4'b0000);
        rd(4'd0, d); chk("R10 restart sets changed", d, 2);
        wr(4'd0, 4'b0000);
        rd(4'd0, d); chk("R10 run to run no change", d, 0);
        wr(4'd15, 4'b0100);
        rd(4'd0, d); chk("R10 setting write", d, 2);
        irq_fire = 1'b1;
        rd(4'd0, d);
        irq_fire = 1'b0;
        chk("R3 read before set", d, 0);
        rd(4'd0, d); chk("R3 set wins over clear", d, 1);

        // R7 / R8 tenths counter
        wr(4'd0, 4'b0000);
        tick(); tick(); tick();
        chk("R7 running before halt", tenths, 3);
        wr(4'd0, 4'b0001);
        chk("R7 halt zeroes", tenths, 0);
        tick(); tick();
        chk("R7 held while halted", tenths, 0);
        chk("R8 no carry halted", tenths_carry, 0);
        wr(4'd0, 4'b0000);
        chk("R7 restart from zero", tenths, 0);
        for (int i = 1; i <= 23; i++) begin
            tick();
            chk("R8 tenths count", tenths, i % 10);
            chk("R8 carry", tenths_carry, (i % 10) == 0);
        end
        @(negedge clk);
        chk("R8 carry idle", tenths_carry, 0);

        // R11 unmapped addresses
        wr(4'd0, 4'b0000);
        rd(4'd15, d); exp_set = d;
        for (int a = 1; a < 15; a++) begin
            rd(4'(a), d);
            chk("R11 unmapped read", d, 0);
            wr(4'(a), 4'hF);
            chk("R11 no clk halt", clk_halted, 0);
            chk("R11 no test", test_mode, 0);
        end
        rd(4'd15, d);
        chk("R11 setting unchanged", d, exp_set);
        chk("R11 int_config unchanged", int_config, 15);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule